// File: doc/BRIEF.md
# Receive Descriptor Writeback Engine

This block keeps a ring of receive descriptors in on-chip descriptor memory and closes out one descriptor each time the receive path finishes a frame. Each entry has three 32-bit words: a buffer address, a status word and a received-length word. The host fills an entry with a buffer address and a negative (two's-complement) buffer size, then sets the ownership bit to give the entry to hardware. The block never moves frame data or checks CRC. It sees only a one-cycle completion pulse that carries the frame length, which includes the 4 CRC bytes, and three error flags.

On a completion the engine reads the status word of the entry at the current ring index. If hardware owns the entry, the engine writes back the status and length, clears ownership, steps the index and pulses the receive interrupt. If the host still owns the entry, the ring is full. The engine then leaves memory untouched and pulses the missed-frame output. The active ring size is set by a length byte whose upper nibble holds log2 of the entry count. The host reads and rewrites any word through a simple RAM port.

Top module: `rxd_writeback`

## Requirements
- R1: While reset is held and in the first cycle after it, rx_int and rx_miss are 0 and ring_idx is 0.
- R2: A host write stores host_wdata into the word chosen by host_word (0 address, 1 status, 2 length) of entry host_entry. A read presents that word on host_rdata one cycle after host_en. Word select 3 reads as zero.
- R3: When the entry at ring_idx has status bit 31 (ownership) set, a completion rewrites the status word with these bits: 31 cleared; 29 framing, 28 overflow, 27 CRC and 26 buffer error; 30 set to the OR of bits 29..26; 25 and 24 (first and last buffer) both set; 23..16 zero; 15..0 unchanged.
- R4: For such a completion, the length word becomes frame_len in bits 11..0, with bits 31..12 zero.
- R5: The buffer size is the negation of status bits 15..0 modulo 2^16. A frame_len greater than that size sets overflow (and bit 30), and the stored length is clamped to the buffer size. A frame_len equal to the size does not overflow.
- R6: Every accepted completion gives a one-cycle rx_int in the second cycle after the frame_done cycle. ring_idx advances in that same cycle, and exactly one outcome is reported per frame_done.
- R7: If ownership is clear at ring_idx, rx_miss pulses in the second cycle after frame_done. No descriptor word changes, ring_idx holds, and rx_int stays low.
- R8: The ring holds 2^n entries, where n is ring_len_code[7:4] clamped to MAX_LOG. ring_idx steps as (ring_idx+1) modulo that size, so a code of 0 gives a one-entry ring.
- R9: A frame_done in the cycle right after an accepted frame_done is dropped. It gives rx_miss in its own second cycle and writes no descriptor.
- R10: rx_int and rx_miss are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_len_code | input | 8 | Upper nibble gives log2 of the active ring size |
| frame_done | input | 1 | One-cycle frame completion pulse |
| frame_len | input | LEN_W | Received length including CRC bytes |
| frame_fram | input | 1 | Framing error of the completed frame |
| frame_crc | input | 1 | CRC error of the completed frame |
| frame_buff | input | 1 | Buffer error of the completed frame |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | Host write when 1, read when 0 |
| host_entry | input | MAX_LOG | Descriptor entry addressed by the host |
| host_word | input | 2 | Word within the entry: 0 address, 1 status, 2 length |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after a read |
| rx_int | output | 1 | Pulse per descriptor returned to the host |
| rx_miss | output | 1 | Pulse per frame dropped |
| ring_idx | output | MAX_LOG | Entry the next completion will use |

## Verification
A wrong ring index shows up at ring_idx two cycles after the completion that caused it. It also shows up in the next completion, which lands on the wrong entry, and later as an unexpected miss or interrupt. A bad write-back field stays hidden in memory until the host reads the entry, so every entry touched is read back through the host port and compared. A latched busy state or a lost drop shows up at once as a missing or extra pulse in the second cycle after a completion, where the scoreboard expects exactly one outcome.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  localparam int WORD_W    = 32;
  localparam int CNT_W     = 16;
  localparam int STAT_OWN  = 31;
  localparam int STAT_ERR  = 30;
  localparam int STAT_FRAM = 29;
  localparam int STAT_OFLO = 28;
  localparam int STAT_CRC  = 27;
  localparam int STAT_BUFF = 26;
  localparam int STAT_STP  = 25;
  localparam int STAT_ENP  = 24;

  typedef enum logic [1:0] {
    DW_ADDR = 2'd0,
    DW_STAT = 2'd1,
    DW_MCNT = 2'd2,
    DW_NONE = 2'd3
  } desc_word_e;

  typedef struct packed {
    logic fram;
    logic crc;
    logic buff;
  } rx_flags_t;

  // Buffer size held as a negative count in the low half of the status word.
  function automatic logic [CNT_W-1:0] buf_size(input logic [CNT_W-1:0] neg_cnt);
    return CNT_W'(~neg_cnt + 1'b1);
  endfunction

  function automatic logic [WORD_W-1:0] status_word(
    input logic [CNT_W-1:0] cnt,
    input logic             fram,
    input logic             oflo,
    input logic             crc,
    input logic             buff
  );
    logic [WORD_W-1:0] w;
    w            = '0;
    w[STAT_OWN]  = 1'b0;
    w[STAT_ERR]  = fram | oflo | crc | buff;
    w[STAT_FRAM] = fram;
    w[STAT_OFLO] = oflo;
    w[STAT_CRC]  = crc;
    w[STAT_BUFF] = buff;
    w[STAT_STP]  = 1'b1;
    w[STAT_ENP]  = 1'b1;
    w[CNT_W-1:0] = cnt;
    return w;
  endfunction

endpackage

// File: rtl/rxd_dpram.sv
module rxd_dpram #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Port B (engine) is written after port A, so it wins a same-address clash.
  always_ff @(posedge clk) begin
    if (a_en && a_we) mem[a_addr] <= a_wdata;
    if (b_we)         mem[b_addr] <= b_wdata;
    if (a_en)         a_rdata     <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/rxd_ring_index.sv
module rxd_ring_index #(
  parameter int MAX_LOG = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [7:0]         len_code,
  input  logic               advance,
  output logic [MAX_LOG-1:0] idx
);

  logic [MAX_LOG-1:0] mask;
  int                 eff_log;

  always_comb begin
    eff_log = int'(len_code[7:4]);
    if (eff_log > MAX_LOG) eff_log = MAX_LOG;
    for (int i = 0; i < MAX_LOG; i++) mask[i] = (i < eff_log);
  end

  always_ff @(posedge clk) begin
    if (rst)          idx <= '0;
    else if (advance) idx <= (idx + 1'b1) & mask;
  end

endmodule

// File: rtl/rxd_wb_ctrl.sv
module rxd_wb_ctrl
  import rxd_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_done,
  input  logic [LEN_W-1:0]  frame_len,
  input  rx_flags_t         frame_flags,
  input  logic [WORD_W-1:0] stat_rd,
  output logic              stat_we,
  output logic [WORD_W-1:0] stat_wd,
  output logic              mcnt_we,
  output logic [WORD_W-1:0] mcnt_wd,
  output logic              advance,
  output logic              rx_int,
  output logic              rx_miss
);

  typedef enum logic {S_IDLE, S_EVAL} st_e;

  st_e              state;
  logic [LEN_W-1:0] len_q;
  rx_flags_t        flags_q;
  logic             drop_q;

  logic             own;
  logic             evaluating;
  logic             take;
  logic             oflo;
  logic [CNT_W-1:0] bsz;
  logic [LEN_W-1:0] keep;

  always_comb begin
    evaluating = (state == S_EVAL);
    own        = stat_rd[STAT_OWN];
    take       = evaluating && own;
    bsz        = buf_size(stat_rd[CNT_W-1:0]);
    oflo       = CNT_W'(len_q) > bsz;
    keep       = oflo ? bsz[LEN_W-1:0] : len_q;
    stat_wd    = status_word(stat_rd[CNT_W-1:0], flags_q.fram, oflo,
                             flags_q.crc, flags_q.buff);
    mcnt_wd    = WORD_W'(keep);
    stat_we    = take;
    mcnt_we    = take;
    advance    = take;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      len_q   <= '0;
      flags_q <= '0;
      drop_q  <= 1'b0;
      rx_int  <= 1'b0;
      rx_miss <= 1'b0;
    end else begin
      rx_int  <= take;
      rx_miss <= drop_q | (evaluating && !own);
      drop_q  <= evaluating && frame_done;
      case (state)
        S_IDLE: if (frame_done) begin
          len_q   <= frame_len;
          flags_q <= frame_flags;
          state   <= S_EVAL;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rxd_writeback.sv
module rxd_writeback
  import rxd_pkg::*;
#(
  parameter int MAX_LOG = 4,
  parameter int LEN_W   = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [7:0]         ring_len_code,
  input  logic               frame_done,
  input  logic [LEN_W-1:0]   frame_len,
  input  logic               frame_fram,
  input  logic               frame_crc,
  input  logic               frame_buff,
  input  logic               host_en,
  input  logic               host_we,
  input  logic [MAX_LOG-1:0] host_entry,
  input  logic [1:0]         host_word,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  output logic               rx_int,
  output logic               rx_miss,
  output logic [MAX_LOG-1:0] ring_idx
);

  localparam int IDX_W  = MAX_LOG;
  localparam int NWORDS = 3;

  logic [WORD_W-1:0] a_rd [NWORDS];
  logic [WORD_W-1:0] b_rd [NWORDS];
  logic [WORD_W-1:0] b_wd [NWORDS];
  logic              b_we [NWORDS];

  logic              stat_we, mcnt_we, advance;
  logic [WORD_W-1:0] stat_wd, mcnt_wd;
  desc_word_e        word_q;
  rx_flags_t         flags;

  assign flags = '{fram: frame_fram, crc: frame_crc, buff: frame_buff};

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    if (g == int'(DW_STAT)) begin : g_stat
      assign b_we[g] = stat_we;
      assign b_wd[g] = stat_wd;
    end else if (g == int'(DW_MCNT)) begin : g_mcnt
      assign b_we[g] = mcnt_we;
      assign b_wd[g] = mcnt_wd;
    end else begin : g_addr
      assign b_we[g] = 1'b0;
      assign b_wd[g] = '0;
    end

    rxd_dpram #(.AW(IDX_W), .DW(WORD_W)) u_ram (
      .clk    (clk),
      .a_en   (host_en && (host_word == 2'(g))),
      .a_we   (host_we),
      .a_addr (host_entry),
      .a_wdata(host_wdata),
      .a_rdata(a_rd[g]),
      .b_we   (b_we[g]),
      .b_addr (ring_idx),
      .b_wdata(b_wd[g]),
      .b_rdata(b_rd[g])
    );
  end

  rxd_ring_index #(.MAX_LOG(MAX_LOG)) u_idx (
    .clk     (clk),
    .rst     (rst),
    .len_code(ring_len_code),
    .advance (advance),
    .idx     (ring_idx)
  );

  rxd_wb_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .frame_done (frame_done),
    .frame_len  (frame_len),
    .frame_flags(flags),
    .stat_rd    (b_rd[int'(DW_STAT)]),
    .stat_we    (stat_we),
    .stat_wd    (stat_wd),
    .mcnt_we    (mcnt_we),
    .mcnt_wd    (mcnt_wd),
    .advance    (advance),
    .rx_int     (rx_int),
    .rx_miss    (rx_miss)
  );

  // Host read path: remember which word was read, select its RAM output.
  always_ff @(posedge clk) begin
    if (rst)                     word_q <= DW_NONE;
    else if (host_en && !host_we) word_q <= desc_word_e'(host_word);
  end

  always_comb begin
    case (word_q)
      DW_ADDR: host_rdata = a_rd[int'(DW_ADDR)];
      DW_STAT: host_rdata = a_rd[int'(DW_STAT)];
      DW_MCNT: host_rdata = a_rd[int'(DW_MCNT)];
      default: host_rdata = '0;
    endcase
  end

endmodule

// File: rtl/rxd_writeback_chk.sv
module rxd_writeback_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_done,
  input logic             rx_int,
  input logic             rx_miss,
  input logic [IDX_W-1:0] ring_idx
);

  logic seen_clk = 1'b0;
  always_ff @(posedge clk) seen_clk <= 1'b1;

  // R1
  a_r1_reset_idle: assert property (@(posedge clk)
    (seen_clk && $past(rst)) |-> (ring_idx == '0 && !rx_int && !rx_miss));

  // R6, R7, R9: each completion yields an outcome two cycles later
  a_r6_one_outcome: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> ##2 (rx_int || rx_miss));

  // R10
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rx_int && rx_miss));

  // R6: interrupt is a single-cycle pulse
  a_r6_int_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_int |=> !rx_int);

  // R7, R8: the index only moves together with an interrupt
  a_r8_idx_moves_on_int: assert property (@(posedge clk) disable iff (rst)
    (seen_clk && ring_idx != $past(ring_idx)) |-> rx_int);

endmodule

bind rxd_writeback rxd_writeback_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .frame_done(frame_done),
  .rx_int    (rx_int),
  .rx_miss   (rx_miss),
  .ring_idx  (ring_idx)
);

// File: tb/tb_rxd_writeback.sv
`timescale 1ns/1ps
module tb_rxd_writeback;

  localparam int ML = 4;
  localparam int NE = 1 << ML;
  localparam logic [15:0] NEG100 = 16'hFF9C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] ring_len_code = 8'h40;
  logic frame_done = 1'b0;
  logic [11:0] frame_len = '0;
  logic frame_fram = 1'b0, frame_crc = 1'b0, frame_buff = 1'b0;
  logic host_en = 1'b0, host_we = 1'b0;
  logic [ML-1:0] host_entry = '0;
  logic [1:0] host_word = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic rx_int, rx_miss;
  logic [ML-1:0] ring_idx;

  always #2.5 clk = ~clk;

  rxd_writeback #(.MAX_LOG(ML), .LEN_W(12)) dut (.*);

  typedef struct {
    bit    is_int;
    int    cyc;
    int    idx;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t mon_it;
  int errors = 0, checks = 0, cyc = 0;
  logic [31:0] m_addr [NE];
  logic [31:0] m_stat [NE];
  logic [31:0] m_mcnt [NE];
  int idx_m = 0, mask_m = NE - 1, last_acc = -10;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && (rx_int || rx_miss)) begin
      if (exp_q.size() == 0) chk(0, "R6", "unexpected outcome", {rx_int, rx_miss}, 0);
      else begin
        mon_it = exp_q.pop_front();
        chk(rx_int == mon_it.is_int && rx_miss == !mon_it.is_int, mon_it.tag,
            "outcome kind", {rx_int, rx_miss}, mon_it.is_int ? 2 : 1);
        chk(cyc == mon_it.cyc, "R6", "outcome cycle", cyc, mon_it.cyc);
        chk(int'(ring_idx) == mon_it.idx, "R6", "ring index", ring_idx, mon_it.idx);
      end
    end else if (!rst && exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
      mon_it = exp_q.pop_front();
      chk(0, mon_it.tag, "missing outcome", 0, mon_it.cyc);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hwrite(int e, int w, logic [31:0] d);
    host_en = 1; host_we = 1; host_entry = ML'(e); host_word = 2'(w); host_wdata = d;
    if (w == 0) m_addr[e] = d;
    if (w == 1) m_stat[e] = d;
    if (w == 2) m_mcnt[e] = d;
    @(negedge clk);
    host_en = 0; host_we = 0;
  endtask

  task automatic hread(int e, int w, output logic [31:0] d);
    host_en = 1; host_we = 0; host_entry = ML'(e); host_word = 2'(w);
    @(negedge clk);
    host_en = 0;
    d = host_rdata;
  endtask

  task automatic arm(int e);
    hwrite(e, 0, 32'h0001_0000 + 32'(e) * 32'h100);
    hwrite(e, 1, {1'b1, 15'd0, NEG100});
    hwrite(e, 2, 32'hDEAD_0000);
  endtask

  task automatic check_entry(int e, string stag, string mtag);
    logic [31:0] d;
    hread(e, 1, d);
    chk(d == m_stat[e], stag, $sformatf("status word entry %0d", e), d, m_stat[e]);
    hread(e, 2, d);
    chk(d == m_mcnt[e], mtag, $sformatf("length word entry %0d", e), d, m_mcnt[e]);
    hread(e, 0, d);
    chk(d == m_addr[e], "R2", $sformatf("address word entry %0d", e), d, m_addr[e]);
  endtask

  task automatic set_code(logic [7:0] c);
    int lg;
    ring_len_code = c;
    lg = int'(c[7:4]);
    if (lg > ML) lg = ML;
    mask_m = (1 << lg) - 1;
  endtask

  // Driver: one-cycle completion pulse; expected outcome pushed to the queue.
  task automatic pulse(int len, bit fr, bit cr, bit bf);
    exp_t it;
    int e;
    logic [31:0] s;
    logic [15:0] bsz;
    bit of;
    int keep;
    frame_done = 1; frame_len = 12'(len);
    frame_fram = fr; frame_crc = cr; frame_buff = bf;
    if (cyc == last_acc + 1) begin
      it = '{0, cyc + 2, idx_m, "R9"};
    end else begin
      last_acc = cyc;
      e = idx_m;
      s = m_stat[e];
      if (s[31]) begin
        bsz = ~s[15:0] + 16'd1;
        of = (len > int'(bsz));
        keep = of ? int'(bsz) : len;
        m_stat[e] = {1'b0, fr | of | cr | bf, fr, of, cr, bf, 2'b11, 8'h00, s[15:0]};
        m_mcnt[e] = 32'(keep);
        idx_m = (idx_m + 1) & mask_m;
        it = '{1, cyc + 2, idx_m, "R6"};
      end else begin
        it = '{0, cyc + 2, idx_m, "R7"};
      end
    end
    exp_q.push_back(it);
    @(negedge clk);
    frame_done = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    idle(3);
    chk(!rx_int && !rx_miss && ring_idx == '0, "R1", "outputs in reset",
        {rx_int, rx_miss, ring_idx}, 0);
    rst = 0;
    idle(1);
    chk(!rx_int && !rx_miss && ring_idx == '0, "R1", "outputs after reset",
        {rx_int, rx_miss, ring_idx}, 0);

    // R2: host port
    hwrite(2, 0, 32'hA5A5_0001);
    hwrite(2, 1, 32'h1234_5678);
    hwrite(2, 2, 32'h0BAD_F00D);
    hread(2, 0, d); chk(d == 32'hA5A5_0001, "R2", "read address", d, 32'hA5A5_0001);
    hread(2, 1, d); chk(d == 32'h1234_5678, "R2", "read status", d, 32'h1234_5678);
    hread(2, 2, d); chk(d == 32'h0BAD_F00D, "R2", "read length", d, 32'h0BAD_F00D);
    hread(2, 3, d); chk(d == 32'h0, "R2", "read unused select", d, 0);

    set_code(8'h40);
    for (int e = 0; e < NE; e++) arm(e);

    pulse(64, 0, 0, 0);   idle(3);   // entry 0 clean
    pulse(80, 0, 1, 0);   idle(3);   // entry 1 crc
    pulse(60, 1, 0, 1);   idle(3);   // entry 2 framing and buffer
    pulse(100, 0, 0, 0);  idle(3);   // entry 3 exact fit
    pulse(101, 0, 0, 0);  idle(3);   // entry 4 overflow by one
    pulse(4095, 0, 1, 0); idle(3);   // entry 5 big overflow
    chk(int'(ring_idx) == 6, "R6", "index after six frames", ring_idx, 6);

    // R7: host-owned entry
    hwrite(6, 1, {16'h0000, NEG100});
    pulse(70, 0, 0, 0); idle(3);
    chk(int'(ring_idx) == 6, "R7", "index held on miss", ring_idx, 6);
    check_entry(6, "R7", "R7");
    hwrite(6, 1, {1'b1, 15'd0, NEG100});
    pulse(72, 0, 0, 0); idle(3);

    // R9: back-to-back completions
    pulse(50, 0, 0, 0);
    pulse(51, 0, 0, 0);
    pulse(52, 0, 0, 0);
    idle(4);
    chk(int'(ring_idx) == 9, "R9", "index after drop", ring_idx, 9);

    check_entry(0, "R3", "R4");
    check_entry(1, "R3", "R4");
    check_entry(2, "R3", "R4");
    check_entry(3, "R5", "R5");
    check_entry(4, "R5", "R5");
    check_entry(5, "R5", "R5");
    check_entry(6, "R3", "R4");
    check_entry(7, "R3", "R4");
    check_entry(8, "R9", "R9");
    check_entry(9, "R9", "R9");

    // R8: one-entry ring
    set_code(8'h00);
    pulse(40, 0, 0, 0); idle(3);
    chk(ring_idx == '0, "R8", "one-entry ring wraps to 0", ring_idx, 0);
    pulse(40, 0, 0, 0); idle(3);
    check_entry(9, "R8", "R8");

    // R8: four-entry ring
    set_code(8'h20);
    for (int e = 0; e < 4; e++) arm(e);
    for (int i = 0; i < 4; i++) begin pulse(30 + i, 0, 0, 0); idle(2); end
    chk(ring_idx == '0, "R8", "four-entry ring wraps", ring_idx, 0);
    check_entry(3, "R8", "R8");

    // R8: oversize code clamps to MAX_LOG
    set_code(8'hF0);
    for (int e = 0; e < NE; e++) arm(e);
    for (int i = 0; i < NE; i++) begin pulse(20 + i, 0, 0, 0); idle(2); end
    chk(ring_idx == '0, "R8", "clamped ring wraps", ring_idx, 0);
    check_entry(15, "R8", "R8");

    idle(4);
    chk(exp_q.size() == 0, "R6", "pending outcomes", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule